// File: doc/BRIEF.md
# Adaptive Bit-Clock Recovery Tracker

This block takes an asynchronous NRZ serial stream and recovers the bit timing from it. Everything advances on a timebase tick. A phase counter measures ticks since the last bit boundary and raises a one-cycle sample strobe in the middle of each bit. The serial level at that strobe is registered as the recovered bit.

The bit period is an estimate that adapts. It starts at a programmed nominal value. At every data transition the counter shows where the edge fell against the expected boundary. An edge that comes early shortens the estimate by one tolerance step, and an edge that comes late lengthens it by one step. The estimate is always kept inside a window around the nominal period. Choose the tolerance near 2% of the nominal period. A large step settles quickly but dithers. A small step may never catch a stream whose rate is far from nominal.

The input is passed through a synchronizer before edges are detected, and the counter restarts its phase on every detected edge. Framing, preamble search and analog slicing belong elsewhere.

Top module: `bitclk_rate_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `period_est` is loaded with `nominal_period`, the phase counter is cleared, and `sample_stb` and `data_bit` are 0.
- R2: In a cycle with `tick_en` low, nothing advances. `serial_in` changes have no effect, `sample_stb` is 0 in the following cycle, and `period_est` and `data_bit` hold.
- R3: An edge is on time when the phase counter has just wrapped to 0, that is, exactly `period_est` ticks after the previous boundary. It leaves the estimate unchanged, and without an edge the estimate never changes. A stream at the nominal period keeps `period_est` at `nominal_period`.
- R4: An early edge, seen while the counter is at least floor(`period_est`/2), lowers the estimate by `tol_step`. With nominal 40, step 2 and a 36-tick stream, the estimate settles at 36.
- R5: A late edge, seen while the counter is nonzero and below floor(`period_est`/2), raises the estimate by `tol_step`. With nominal 40, step 2 and a 44-tick stream, the estimate settles at 44.
- R6: After every edge the estimate is clamped to [max(nominal − 4·step, 2), min(nominal + 4·step, 16383)]. With nominal 40 and step 2, a 30-tick stream holds it at 32 and a 50-tick stream holds it at 48.
- R7: `sample_stb` is a one-cycle pulse, raised one clock after a tick on which the counter equals floor(`period_est`/2) and no edge is seen. `data_bit` takes the synchronized input on that strobe and holds otherwise. With an estimate of 40 the strobe is visible 23 cycles after an input transition when ticks run every cycle.
- R8: For a stream whose period equals the estimate, each bit is sampled exactly once and in order, including runs of equal bits.
- R9: When the stream period lies between two reachable steps, the estimate alternates between them on successive edges. With nominal 200, step 4 and a 210-tick stream, it alternates between 208 and 212.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timebase tick; all state advances only when high |
| serial_in | input | 1 | Asynchronous NRZ serial data |
| nominal_period | input | 14 | Nominal bit period in ticks |
| tol_step | input | 8 | Adjustment step in ticks |
| sample_stb | output | 1 | One-cycle mid-bit sample strobe |
| data_bit | output | 1 | Recovered data bit |
| period_est | output | 14 | Current bit-period estimate in ticks |

## Verification
Four streams share nominal 40 and step 2. The 40-tick and 36-tick streams carry mixed data with runs and are scored bit by bit. They separate an estimate that holds from one that converges downward. The 44-tick and 50-tick streams separate upward convergence from saturation at the upper clamp, and a 30-tick stream does the same at the lower clamp. A 210-tick stream against nominal 200 must produce the two-value dither. A single timed transition fixes the strobe position, and a stretch with the tick held low while the input toggles must leave every output unchanged.

// File: rtl/rt_pkg.sv
package rt_pkg;
   typedef enum logic [1:0] {
      PH_ONTIME = 2'd0,
      PH_LATE   = 2'd1,
      PH_EARLY  = 2'd2
   } phase_e;
endpackage

// File: rtl/rt_din_sync.sv
module rt_din_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic din,
   output logic data_s,
   output logic edge_p
);
   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("rt_din_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst)       chain[g] <= 1'b0;
            else if (tick) chain[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst)       chain[g] <= 1'b0;
            else if (tick) chain[g] <= chain[g-1];
         end
      end
   end

   assign data_s = chain[STAGES-1];
   assign edge_p = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/rt_phase_ctr.sv
module rt_phase_ctr #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic         edge_p,
   input  logic         data_s,
   input  logic [W-1:0] est,
   output logic [W-1:0] cnt,
   output logic         stb,
   output logic         bit_o
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] half;
   logic [W-1:0] wrap_at;
   logic         hit_mid;

   assign half    = est >> 1;
   assign wrap_at = est - W'(1);
   assign hit_mid = !edge_p && (cnt_q == half);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         stb   <= 1'b0;
         bit_o <= 1'b0;
      end else if (tick) begin
         if (edge_p)               cnt_q <= W'(1);
         else if (cnt_q >= wrap_at) cnt_q <= '0;
         else                      cnt_q <= cnt_q + W'(1);
         stb <= hit_mid;
         if (hit_mid) bit_o <= data_s;
      end else begin
         stb <= 1'b0;
      end
   end

   assign cnt = cnt_q;

   assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb);
   assert_bit_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !stb |-> $stable(bit_o));
endmodule

// File: rtl/rt_period_adapt.sv
module rt_period_adapt
   import rt_pkg::*;
#(
   parameter int W       = 14,
   parameter int TW      = 8,
   parameter int SPAN    = 4,
   parameter int MIN_EST = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          edge_p,
   input  logic [W-1:0]  cnt,
   input  logic [W-1:0]  nominal,
   input  logic [TW-1:0] tol,
   output logic [W-1:0]  est
);
   localparam int XW = W + $clog2(SPAN + 1) + 2;
   localparam logic [XW-1:0] MAXV  = XW'({W{1'b1}});
   localparam logic [XW-1:0] FLOOR = XW'(MIN_EST);

   logic [W-1:0]  est_q;
   logic [XW-1:0] est_x, nom_x, tol_x, span_x, hi_raw, lim_hi, lim_lo, cand, clamped;
   phase_e        ph;

   always_comb begin
      est_x  = XW'(est_q);
      nom_x  = XW'(nominal);
      tol_x  = XW'(tol);
      span_x = tol_x * XW'(SPAN);
      hi_raw = nom_x + span_x;
      lim_hi = (hi_raw > MAXV) ? MAXV : hi_raw;
      lim_lo = (nom_x >= span_x + FLOOR) ? (nom_x - span_x) : FLOOR;
      if (cnt == '0)              ph = PH_ONTIME;
      else if (cnt < (est_q >> 1)) ph = PH_LATE;
      else                        ph = PH_EARLY;
      case (ph)
         PH_LATE:  cand = est_x + tol_x;
         PH_EARLY: cand = (est_x >= tol_x) ? (est_x - tol_x) : '0;
         default:  cand = est_x;
      endcase
      if (cand > lim_hi)      clamped = lim_hi;
      else if (cand < lim_lo) clamped = lim_lo;
      else                    clamped = cand;
   end

   always_ff @(posedge clk) begin
      if (rst)                 est_q <= nominal;
      else if (tick && edge_p) est_q <= W'(clamped);
   end

   assign est = est_q;

   assert_est_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !(tick && edge_p) |=> $stable(est_q));
   assert_est_bounds_R6: assert property (@(posedge clk) disable iff (rst)
      (tick && edge_p) |=> (XW'(est_q) <= $past(lim_hi)) && (XW'(est_q) >= $past(lim_lo)));
endmodule

// File: rtl/bitclk_rate_tracker.sv
module bitclk_rate_tracker #(
   parameter int PERIOD_W    = 14,
   parameter int TOL_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CLAMP_STEPS = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                tick_en,
   input  logic                serial_in,
   input  logic [PERIOD_W-1:0] nominal_period,
   input  logic [TOL_W-1:0]    tol_step,
   output logic                sample_stb,
   output logic                data_bit,
   output logic [PERIOD_W-1:0] period_est
);
   localparam int MIN_EST = 2;

   if (TOL_W > PERIOD_W) begin : g_bad_tol
      $error("bitclk_rate_tracker: TOL_W must not exceed PERIOD_W");
   end
   if (CLAMP_STEPS < 1) begin : g_bad_span
      $error("bitclk_rate_tracker: CLAMP_STEPS must be at least 1");
   end
   if (PERIOD_W < 4) begin : g_bad_width
      $error("bitclk_rate_tracker: PERIOD_W too small");
   end

   logic                data_s;
   logic                edge_p;
   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] est;

   rt_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_en),
      .din    (serial_in),
      .data_s (data_s),
      .edge_p (edge_p)
   );

   rt_phase_ctr #(.W(PERIOD_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_en),
      .edge_p (edge_p),
      .data_s (data_s),
      .est    (est),
      .cnt    (cnt),
      .stb    (sample_stb),
      .bit_o  (data_bit)
   );

   rt_period_adapt #(
      .W       (PERIOD_W),
      .TW      (TOL_W),
      .SPAN    (CLAMP_STEPS),
      .MIN_EST (MIN_EST)
   ) u_adapt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_en),
      .edge_p  (edge_p),
      .cnt     (cnt),
      .nominal (nominal_period),
      .tol     (tol_step),
      .est     (est)
   );

   assign period_est = est;

   assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> !sample_stb);
endmodule

// File: tb/bitclk_rate_tracker_tb_top.sv
module bitclk_rate_tracker_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_en = 1'b1;
   logic        serial_in = 1'b0;
   logic [13:0] nominal_period = 14'd40;
   logic [7:0]  tol_step = 8'd2;
   logic        sample_stb;
   logic        data_bit;
   logic [13:0] period_est;

   int n_checks = 0;
   int n_fail   = 0;
   bit armed    = 1'b0;
   bit frozen   = 1'b0;
   int frozen_stb = 0;
   bit exp_q[$];

   localparam logic [31:0] PATTERN = 32'hC3A5_96F0;

   always #5 clk = ~clk;

   bitclk_rate_tracker dut_i (
      .clk            (clk),
      .rst            (rst),
      .tick_en        (tick_en),
      .serial_in      (serial_in),
      .nominal_period (nominal_period),
      .tol_step       (tol_step),
      .sample_stb     (sample_stb),
      .data_bit       (data_bit),
      .period_est     (period_est)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on each strobe
   always @(negedge clk) begin
      if (sample_stb && frozen) frozen_stb++;
      if (sample_stb && armed) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected extra strobe", 1, 0);
         end else begin
            bit e;
            e = exp_q.pop_front();
            chk(data_bit == e, "R8 sampled bit", int'(data_bit), int'(e));
         end
      end
   end

   task automatic do_reset(input int nom, input int tol);
      @(negedge clk);
      rst = 1'b1;
      serial_in = 1'b0;
      nominal_period = 14'(nom);
      tol_step = 8'(tol);
      repeat (3) @(negedge clk);
      chk(period_est == 14'(nom), "R1 est after reset", int'(period_est), nom);
      chk(sample_stb == 1'b0, "R1 strobe in reset", int'(sample_stb), 0);
      chk(data_bit == 1'b0, "R1 data bit in reset", int'(data_bit), 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic send_bit(input bit b, input int per, input bit push);
      if (push) exp_q.push_back(b);
      serial_in = b;
      repeat (per) @(negedge clk);
   endtask

   task automatic lead_in(input int per, input int n);
      for (int i = 0; i < n; i++) send_bit((i % 2) == 0, per, 1'b0);
   endtask

   task automatic scored_run(input int per, input int n);
      armed = 1'b1;
      for (int i = 0; i < n; i++) send_bit(PATTERN[i], per, 1'b1);
      armed = 1'b0;
      chk(exp_q.size() == 0, "R8 all bits sampled", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      // R1 / R3: nominal-rate stream keeps the estimate and is scored
      do_reset(40, 2);
      lead_in(40, 12);
      chk(period_est == 14'd40, "R3 est at nominal rate", int'(period_est), 40);
      scored_run(40, 24);
      chk(period_est == 14'd40, "R3 est held after runs", int'(period_est), 40);

      // R7: strobe timing after a single transition, est 40
      begin
         int found;
         bit nv;
         found = -1;
         nv = ~serial_in;
         serial_in = nv;
         for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (sample_stb && found < 0) begin
               found = k;
               chk(data_bit == nv, "R7 bit taken on strobe", int'(data_bit), int'(nv));
            end
         end
         chk(found == 23, "R7 strobe delay", found, 23);
      end

      // R2: tick held low, input toggling has no effect
      begin
         logic [13:0] est_hold;
         logic        bit_hold;
         tick_en = 1'b0;
         @(negedge clk);
         est_hold = period_est;
         bit_hold = data_bit;
         frozen = 1'b1;
         frozen_stb = 0;
         for (int i = 0; i < 6; i++) begin
            serial_in = ~serial_in;
            repeat (20) @(negedge clk);
         end
         chk(period_est == est_hold, "R2 est frozen", int'(period_est), int'(est_hold));
         chk(data_bit == bit_hold, "R2 data bit frozen", int'(data_bit), int'(bit_hold));
         chk(frozen_stb == 0, "R2 no strobe while frozen", frozen_stb, 0);
         frozen = 1'b0;
         tick_en = 1'b1;
      end

      // R4: shorter stream converges downward
      do_reset(40, 2);
      lead_in(36, 12);
      chk(period_est == 14'd36, "R4 est converged to 36", int'(period_est), 36);
      scored_run(36, 24);
      chk(period_est == 14'd36, "R4 est stays 36", int'(period_est), 36);

      // R5: longer stream converges upward
      do_reset(40, 2);
      lead_in(44, 12);
      chk(period_est == 14'd44, "R5 est converged to 44", int'(period_est), 44);
      scored_run(44, 16);

      // R6: upper and lower clamps
      do_reset(40, 2);
      lead_in(50, 14);
      chk(period_est == 14'd48, "R6 upper clamp", int'(period_est), 48);
      do_reset(40, 2);
      lead_in(30, 14);
      chk(period_est == 14'd32, "R6 lower clamp", int'(period_est), 32);

      // R9: unreachable period gives a two-value dither
      do_reset(200, 4);
      lead_in(210, 10);
      begin
         int prev;
         prev = int'(period_est);
         chk(prev == 208 || prev == 212, "R9 est in dither pair", prev, 208);
         for (int i = 0; i < 4; i++) begin
            send_bit((i % 2) == 0, 210, 1'b0);
            chk(period_est == 14'd208 || period_est == 14'd212,
                "R9 est in dither pair", int'(period_est), 212);
            chk(int'(period_est) != prev, "R9 est alternates", int'(period_est), prev);
            prev = int'(period_est);
         end
      end

      // R1: reset restores nominal after adaptation
      do_reset(40, 2);
      finish_run();
   end
endmodule